// File: doc/BRIEF.md
# Instruction Fetch Address Translator

This block sits in the fetch pipeline. It turns an instruction-fetch virtual address into a physical address, or into a fault code. Each request takes one of four routes:

- **Privileged-code fetch**: selected by the low bit of the fetch PC. It is passed straight through, masked to the implemented physical width.
- **Physical-mode request**: the virtual address is used unchanged.
- **Superpage window**: a fixed direct-mapped window that only kernel mode may use.
- **Page-mapped address**: resolved through an external TLB lookup port. The port answers in the same cycle with hit, physical page number and one execute-enable bit per privilege mode.

Every route except the privileged one then goes through two checks. The implemented-width check raises a machine check. The cacheability rule marks uncached addresses, and because the request is a fetch, an uncached address raises an unimplemented-access fault.

Requests enter on a valid/ready port and results leave on a valid/ready port through a single output register.

- A request is taken on any clock where `req_valid` and `req_ready` are both high.
- `req_ready` is high whenever the output register is empty or is being drained in that cycle.
- While `rsp_valid` is high and `rsp_ready` is low, the response holds still and no new request is taken.
- The TLB port is combinational. It is only meaningful while a page-mapped request is on the input.

Top module: `ifetch_xlate`

## Requirements
- R1: When `pc_pal` is 1, the response carries PA = VA with bits 1:0 cleared and bits 63:44 cleared, with fault code 0 (none), `rsp_uncached` = 0, and `tlb_lookup` stays low.
- R2: When `pc_pal` = 0 and `req_phys` = 1, the physical address is the virtual address unchanged, then subject to R9 and R10.
- R3: With no bypass, a VA whose bits 63:47 are not all equal gives fault code 1 (access violation), PA 0, not uncached.
- R4: A valid VA with VA[47:41] = 0x7E is a superpage. In a mode other than kernel (mode code 0), it gives fault code 1 with PA 0.
- R5: A kernel-mode superpage takes PA = VA[43:0]. If PA bit 40 is 1, bits 43:40 become 1111; otherwise bits 43:40 become 0000. R9 and R10 then apply.
- R6: Any other valid VA raises `tlb_lookup`, with `tlb_vpn` = VA[47:13] and `tlb_asn` = `cur_asn`. A miss gives fault code 2 (page fault) with PA 0.
- R7: On a TLB hit, PA = (`tlb_ppn` << 13) + (VA[12:0] with bits 1:0 cleared).
- R8: On a TLB hit, if `tlb_xen` bit indexed by `cur_mode` is 0, the result is fault code 1 with PA 0.
- R9: A checked PA with any of bits 63:44 set gives fault code 3 (machine check), PA as formed, not uncached.
- R10: A checked PA with bit 43 set gives `rsp_uncached` = 1 and fault code 4 (unimplemented). Bits 42:35 are cleared, unless all of them were 1 (I/O control space), in which case the PA is kept.
- R11: `req_ready` = !`rsp_valid` || `rsp_ready`. An accepted request appears on the response one clock later. A stalled response holds all its fields. After reset `rsp_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request may be taken |
| req_vaddr | input | 64 | Fetch virtual address |
| pc_pal | input | 1 | Low bit of fetch PC (privileged-code fetch) |
| req_phys | input | 1 | Physical-mode request |
| cur_mode | input | 2 | Current privilege mode, 0 = kernel |
| cur_asn | input | 8 | Current address-space number |
| tlb_lookup | output | 1 | TLB lookup requested this cycle |
| tlb_vpn | output | 35 | Virtual page number for lookup |
| tlb_asn | output | 8 | Address-space number for lookup |
| tlb_hit | input | 1 | TLB hit |
| tlb_ppn | input | 31 | Physical page number on hit |
| tlb_xen | input | 4 | Execute enable, one bit per mode |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response consumed |
| rsp_paddr | output | 64 | Physical address |
| rsp_uncached | output | 1 | Uncached access |
| rsp_fault | output | 3 | Fault code (0 none, 1 access violation, 2 page fault, 3 machine check, 4 unimplemented) |

## Verification
The bench builds the block with its default parameters: 64-bit VA, 44-bit implemented PA, 8 KB pages, a 2-bit mode and an 8-bit ASN. The superpage, sign-extension and I/O-space positions are fixed in this configuration, so they can be reached directly.

With only four modes and four execute-enable bits, the bench sweeps every mode against every enable mask, for both hit and miss. It does the same with every mode against superpage addresses on either side of bit 40. Page numbers are chosen so that the mapped route also reaches the uncached and I/O-space corners.

// File: rtl/ifx_pkg.sv
package ifx_pkg;
  localparam int SP_LO  = 41;      // low bit of superpage selector
  localparam logic [6:0] SP_TAG = 7'h7E;
  localparam int SX_BIT = 40;      // superpage sign-extension bit
  localparam int IO_LO  = 35;      // low bit of the cleared field on uncached

  typedef enum logic [2:0] {
    P_PAL, P_PHYS, P_BADVA, P_SUPER, P_MAPPED
  } xpath_e;

  typedef enum logic [2:0] {
    F_NONE  = 3'd0,
    F_ACV   = 3'd1,
    F_PAGE  = 3'd2,
    F_MCHK  = 3'd3,
    F_UNIMP = 3'd4
  } fault_e;
endpackage

// File: rtl/ifx_path_sel.sv
module ifx_path_sel
  import ifx_pkg::*;
#(
  parameter int VA_W = 64,
  parameter int VA_HI = 47
) (
  input  logic [VA_W-1:SP_LO] va_hi,
  input  logic                pal,
  input  logic                phys,
  output xpath_e              path
);
  localparam int SPW = VA_HI - SP_LO + 1;

  logic va_ok;
  logic is_super;

  always_comb begin
    va_ok    = (va_hi[VA_W-1:VA_HI] == '0) || (va_hi[VA_W-1:VA_HI] == '1);
    is_super = (va_hi[VA_HI:SP_LO] == SPW'(SP_TAG));
    if (pal)            path = P_PAL;
    else if (phys)      path = P_PHYS;
    else if (!va_ok)    path = P_BADVA;
    else if (is_super)  path = P_SUPER;
    else                path = P_MAPPED;
  end
endmodule

// File: rtl/ifx_pa_build.sv
module ifx_pa_build
  import ifx_pkg::*;
#(
  parameter int VA_W = 64,
  parameter int PA_W = 44,
  parameter int PG_SH = 13,
  parameter int MODE_W = 2
) (
  input  xpath_e                   path,
  input  logic [VA_W-1:0]          va,
  input  logic [MODE_W-1:0]        mode,
  input  logic                     hit,
  input  logic [PA_W-PG_SH-1:0]    ppn,
  input  logic [(1<<MODE_W)-1:0]   xen,
  output logic [VA_W-1:0]          raw_pa,
  output fault_e                   early_flt,
  output logic                     chk_en
);
  localparam logic [VA_W-1:0] IMPL_MASK = {{(VA_W-PA_W){1'b0}}, {PA_W{1'b1}}};

  always_comb begin
    raw_pa    = '0;
    early_flt = F_NONE;
    chk_en    = 1'b0;
    case (path)
      P_PAL: begin
        raw_pa = {va[VA_W-1:2], 2'b00} & IMPL_MASK;
      end
      P_PHYS: begin
        raw_pa = va;
        chk_en = 1'b1;
      end
      P_BADVA: early_flt = F_ACV;
      P_SUPER: begin
        if (mode != '0) begin
          early_flt = F_ACV;
        end else begin
          raw_pa = va & IMPL_MASK;
          if (raw_pa[SX_BIT]) raw_pa[PA_W-1:SX_BIT] = '1;
          else                raw_pa[PA_W-1:SX_BIT] = '0;
          chk_en = 1'b1;
        end
      end
      default: begin
        if (!hit)            early_flt = F_PAGE;
        else if (!xen[mode]) early_flt = F_ACV;
        else begin
          raw_pa = VA_W'({ppn, va[PG_SH-1:2], 2'b00});
          chk_en = 1'b1;
        end
      end
    endcase
  end
endmodule

// File: rtl/ifx_post_chk.sv
module ifx_post_chk
  import ifx_pkg::*;
#(
  parameter int VA_W = 64,
  parameter int PA_W = 44
) (
  input  logic [VA_W-1:0] raw_pa,
  input  logic            chk_en,
  input  fault_e          early_flt,
  output logic [VA_W-1:0] pa,
  output logic            uncached,
  output fault_e          flt
);
  always_comb begin
    pa       = raw_pa;
    uncached = 1'b0;
    flt      = early_flt;
    if (chk_en && early_flt == F_NONE) begin
      if (|raw_pa[VA_W-1:PA_W]) begin
        flt = F_MCHK;
      end else if (raw_pa[PA_W-1]) begin
        uncached = 1'b1;
        flt      = F_UNIMP;
        if (!(&raw_pa[PA_W-2:IO_LO])) pa[PA_W-2:IO_LO] = '0;
      end
    end
  end
endmodule

// File: rtl/ifetch_xlate.sv
module ifetch_xlate
  import ifx_pkg::*;
#(
  parameter int VA_W = 64,
  parameter int VA_HI = 47,
  parameter int PA_W = 44,
  parameter int PG_SH = 13,
  parameter int ASN_W = 8,
  parameter int MODE_W = 2,
  localparam int VPN_W = VA_HI - PG_SH + 1,
  localparam int PPN_W = PA_W - PG_SH,
  localparam int NMODES = 1 << MODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic              pc_pal,
  input  logic              req_phys,
  input  logic [MODE_W-1:0] cur_mode,
  input  logic [ASN_W-1:0]  cur_asn,
  output logic              tlb_lookup,
  output logic [VPN_W-1:0]  tlb_vpn,
  output logic [ASN_W-1:0]  tlb_asn,
  input  logic              tlb_hit,
  input  logic [PPN_W-1:0]  tlb_ppn,
  input  logic [NMODES-1:0] tlb_xen,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [VA_W-1:0]   rsp_paddr,
  output logic              rsp_uncached,
  output logic [2:0]        rsp_fault
);
  xpath_e          path;
  logic [VA_W-1:0] raw_pa, fin_pa;
  fault_e          early_flt, fin_flt;
  logic            chk_en, fin_unc;
  logic            accept;

  ifx_path_sel #(.VA_W(VA_W), .VA_HI(VA_HI)) u_sel (
    .va_hi (req_vaddr[VA_W-1:SP_LO]),
    .pal   (pc_pal),
    .phys  (req_phys),
    .path  (path)
  );

  ifx_pa_build #(.VA_W(VA_W), .PA_W(PA_W), .PG_SH(PG_SH), .MODE_W(MODE_W)) u_build (
    .path      (path),
    .va        (req_vaddr),
    .mode      (cur_mode),
    .hit       (tlb_hit),
    .ppn       (tlb_ppn),
    .xen       (tlb_xen),
    .raw_pa    (raw_pa),
    .early_flt (early_flt),
    .chk_en    (chk_en)
  );

  ifx_post_chk #(.VA_W(VA_W), .PA_W(PA_W)) u_chk (
    .raw_pa    (raw_pa),
    .chk_en    (chk_en),
    .early_flt (early_flt),
    .pa        (fin_pa),
    .uncached  (fin_unc),
    .flt       (fin_flt)
  );

  assign tlb_lookup = req_valid && (path == P_MAPPED);
  assign tlb_vpn    = req_vaddr[VA_HI:PG_SH];
  assign tlb_asn    = cur_asn;

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid    <= 1'b0;
      rsp_paddr    <= '0;
      rsp_uncached <= 1'b0;
      rsp_fault    <= '0;
    end else if (accept) begin
      rsp_valid    <= 1'b1;
      rsp_paddr    <= fin_pa;
      rsp_uncached <= fin_unc;
      rsp_fault    <= fin_flt;
    end else if (rsp_ready) begin
      rsp_valid    <= 1'b0;
    end
  end

  // R1: privileged fetch never faults
  a_r1_pal_clean: assert property (@(posedge clk) disable iff (!rst_n)
    accept && pc_pal |=> rsp_fault == F_NONE && !rsp_uncached);
  // R4: superpage outside kernel mode is refused
  a_r4_super_user: assert property (@(posedge clk) disable iff (!rst_n)
    accept && path == P_SUPER && cur_mode != '0 |=> rsp_fault == F_ACV);
  // R6: lookup only off the bypass routes
  a_r6_lookup_route: assert property (@(posedge clk) disable iff (!rst_n)
    tlb_lookup |-> !pc_pal && !req_phys);
  // R9: a clean response is inside the implemented width
  a_r9_impl_width: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault == F_NONE |-> rsp_paddr[VA_W-1:PA_W] == '0);
  // R10: uncached fetch always faults
  a_r10_unc_faults: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_uncached |-> rsp_fault == F_UNIMP && rsp_paddr[PA_W-1]);
  // R11: stalled response holds
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_paddr)
      && $stable(rsp_fault) && $stable(rsp_uncached));
  a_r11_empty_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> req_ready);
endmodule

// File: tb/test_ifetch_xlate.sv
module test_ifetch_xlate;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        req_valid = 0;
  logic        req_ready;
  logic [63:0] req_vaddr = '0;
  logic        pc_pal = 0;
  logic        req_phys = 0;
  logic [1:0]  cur_mode = 0;
  logic [7:0]  cur_asn = 0;
  logic        tlb_lookup;
  logic [34:0] tlb_vpn;
  logic [7:0]  tlb_asn;
  logic        tlb_hit = 0;
  logic [30:0] tlb_ppn = '0;
  logic [3:0]  tlb_xen = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1;
  logic [63:0] rsp_paddr;
  logic        rsp_uncached;
  logic [2:0]  rsp_fault;

  int n_vec = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  ifetch_xlate i_ifetch_xlate (.*);

  function automatic logic [67:0] model(logic [63:0] va, logic pal, logic phys,
      logic [1:0] mode, logic hit, logic [30:0] ppn, logic [3:0] xen);
    logic [63:0] pa = 0;
    logic [2:0] f = 0;
    logic u = 0;
    logic chk = 0;
    if (pal) pa = va & 64'h0000_0FFF_FFFF_FFFC;
    else begin
      if (phys) begin pa = va; chk = 1; end
      else if (va[63:47] != 17'h0 && va[63:47] != 17'h1FFFF) f = 1;
      else if (va[47:41] == 7'h7E) begin
        if (mode != 0) f = 1;
        else begin
          pa = va & 64'h0000_0FFF_FFFF_FFFF;
          if (pa[40]) pa = pa | 64'h0000_0F00_0000_0000;
          else        pa = pa & 64'h0000_00FF_FFFF_FFFF;
          chk = 1;
        end
      end else if (!hit) f = 2;
      else if (!xen[mode]) f = 1;
      else begin pa = (64'(ppn) << 13) + (va & 64'h1FFC); chk = 1; end
      if (chk) begin
        if ((pa >> 44) != 0) f = 3;
        else if (pa[43]) begin
          u = 1; f = 4;
          if (pa[42:35] != 8'hFF) pa = pa & ~(64'hFF << 35);
        end
      end
    end
    return {f, u, pa};
  endfunction

  task automatic chk(string req, logic [67:0] act, logic [67:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // drives at a negedge, checks lookup port, then the response one clock on
  task automatic apply(string req, logic [63:0] va, logic pal, logic phys,
      logic [1:0] mode, logic hit, logic [30:0] ppn, logic [3:0] xen);
    logic [67:0] e;
    logic exp_lk;
    req_vaddr = va; pc_pal = pal; req_phys = phys; cur_mode = mode;
    tlb_hit = hit; tlb_ppn = ppn; tlb_xen = xen; cur_asn = va[20:13];
    req_valid = 1;
    e = model(va, pal, phys, mode, hit, ppn, xen);
    exp_lk = !pal && !phys && (va[63:47] == 17'h0 || va[63:47] == 17'h1FFFF)
             && va[47:41] != 7'h7E;
    #1;
    // R6 lookup port
    chk("R6", {24'h0, tlb_lookup, tlb_vpn, tlb_asn}, {24'h0, exp_lk, va[47:13], va[20:13]});
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    chk(req, {rsp_fault, rsp_uncached, rsp_paddr}, e);
    chk("R11", {67'h0, rsp_valid}, 68'h1);
  endtask

  initial begin
    #(20 * 100000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11", {66'h0, rsp_valid, req_ready}, 68'h1);
    rst_n = 1;
    @(negedge clk);

    // R1 privileged route
    apply("R1", 64'hFFFF_FFFF_FFFF_FFFF, 1, 0, 3, 0, 0, 0);
    apply("R1", 64'h0000_0800_0000_1237, 1, 1, 1, 0, 0, 0);
    apply("R1", 64'h1234_5678_9ABC_DEF1, 1, 0, 2, 1, 31'h7FFFFFFF, 4'hF);

    // R2/R9/R10 physical route
    apply("R2", 64'h0000_0012_3456_789B, 0, 1, 2, 0, 0, 0);
    apply("R9", 64'h0000_1000_0000_0000, 0, 1, 0, 0, 0, 0);
    apply("R9", 64'h8000_0000_0000_0000, 0, 1, 0, 0, 0, 0);
    apply("R10", 64'h0000_0ABC_DEF0_1234, 0, 1, 0, 0, 0, 0);
    apply("R10", 64'h0000_0FF8_0000_0040, 0, 1, 0, 0, 0, 0);

    // R3 bad virtual addresses
    apply("R3", 64'h0001_0000_0000_0000, 0, 0, 0, 1, 1, 4'hF);
    apply("R3", 64'hFFFF_7FFF_FFFF_FFFF, 0, 0, 0, 1, 1, 4'hF);
    apply("R3", 64'h4000_0000_0000_2000, 0, 0, 3, 1, 1, 4'hF);

    // R4/R5/R10 superpage across modes and both sides of bit 40
    for (int m = 0; m < 4; m++) begin
      apply("R5", 64'hFFFF_FC00_1234_5678, 0, 0, 2'(m), 1, 1, 4'hF);
      apply("R5", 64'hFFFF_FD23_4567_8ABC, 0, 0, 2'(m), 1, 1, 4'hF);
      apply("R10", 64'hFFFF_FDFF_8000_0000, 0, 0, 2'(m), 0, 0, 0);
      apply("R4", 64'hFFFF_FDFF_FFFF_FFFC, 0, 0, 2'(m), 0, 0, 0);
    end

    // R6/R7/R8/R10 mapped route: all modes x all enable masks x hit/miss
    for (int m = 0; m < 4; m++)
      for (int x = 0; x < 16; x++)
        for (int h = 0; h < 2; h++) begin
          logic [30:0] p;
          p = 31'(x * 32'h0123_4567 + m * 32'h1357);
          if (x == 5)  p = 31'h4000_0000 | p;
          if (x == 9)  p = 31'h7FC0_0000 | p;
          apply("R8", 64'h0000_1234_5678_9ABF ^ (64'(x) << 13) ^ (64'(m) << 30),
                0, 0, 2'(m), h[0], p, 4'(x));
        end
    apply("R7", 64'hFFFF_8000_0000_1FFF, 0, 0, 1, 1, 31'h0000_0001, 4'h2);
    apply("R6", 64'h0000_7FFF_FFFF_E000, 0, 0, 0, 0, 0, 4'hF);

    // R11 back-pressure
    @(negedge clk);
    rsp_ready = 0;
    req_vaddr = 64'h0000_0000_0001_2340; req_phys = 1; pc_pal = 0; req_valid = 1;
    @(posedge clk); @(negedge clk);
    chk("R11", {3'h0, rsp_valid, req_ready, 63'h0}, {3'h0, 1'b1, 1'b0, 63'h0});
    req_vaddr = 64'h0000_0000_0005_5550;
    repeat (2) begin
      @(posedge clk); @(negedge clk);
      chk("R11", {rsp_fault, rsp_uncached, rsp_paddr}, {3'd0, 1'b0, 64'h0000_0000_0001_2340});
    end
    rsp_ready = 1;
    @(posedge clk); @(negedge clk);
    chk("R11", {rsp_fault, rsp_uncached, rsp_paddr}, {3'd0, 1'b0, 64'h0000_0000_0005_5550});
    req_valid = 0;
    @(posedge clk); @(negedge clk);
    chk("R11", {67'h0, rsp_valid}, 68'h0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule